// File: doc/BRIEF.md
# Flash Program/Erase Pulse Sequencer

This block drives the program and erase enables of an on-chip flash array under a pulse-then-verify retry loop. A start strobe selects one of three operations: normal programming of a 128-byte unit, additional (touch-up) programming, or block erase. The block then alternates between a timed enable pulse and a verify phase. During the verify phase an external comparison stage is asked for a pass or fail verdict. The sequence ends with success on the first passing verify. If verify still fails after the last permitted attempt, the sequence ends with failure.

All dwell times are counted in ticks of a 1 µs strobe, so pulse widths do not depend on the system clock. Normal programming uses a short pulse for the early attempts and a long pulse for the later ones, up to a large attempt ceiling. Additional programming uses a very short pulse and a small attempt ceiling. For erase, the pulse width in milliseconds and the attempt ceiling are runtime inputs, captured at the start. Their product bounds the total erase time. Time spent in verify never counts as pulse time.

Top module: `fpe_pulse_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `prog_en`, `erase_en`, `verify_req`, `done` and `fail` are all 0.
- R2: In a normal program sequence, attempts 1 to SWITCH_N hold `prog_en` high for exactly SHORT_US ticks of `us_tick`.
- R3: In a normal program sequence, attempts from SWITCH_N+1 up to PROG_MAX hold `prog_en` high for exactly LONG_US ticks, and at most PROG_MAX attempts are made.
- R4: An additional-program sequence holds `prog_en` high for exactly ADD_US ticks per attempt, with at most ADD_MAX attempts.
- R5: An erase sequence holds `erase_en` high for `erase_ms` × US_PER_MS ticks per attempt, with at most `erase_max` attempts. Both inputs are captured when the erase starts, and later changes to them have no effect on the running sequence. A captured `erase_max` of 0 allows one attempt.
- R6: In the cycle after the tick that ends a pulse, the enable is 0 and `verify_req` is 1. `verify_req` stays 1, with both enables 0, until `verify_done` is seen.
- R7: A `verify_done` with `verify_pass`=1 ends the sequence: `done` is 1 for exactly one cycle, starting the cycle after `verify_done`, with `fail`=0.
- R8: A `verify_done` with `verify_pass`=0 on the last permitted attempt ends the sequence with `done` and `fail` both 1 for one cycle. Otherwise the next pulse starts in the cycle after `verify_done`.
- R9: Start strobes seen while a sequence is running (in a pulse or in verify) are ignored. They do not change the pulse widths or the attempt count, and they start nothing after the sequence ends.
- R10: Pulse time advances only on cycles where `us_tick` is 1. With sparse ticks the enable stays high for more clock cycles but for the same number of ticks.
- R11: Simultaneous start strobes from idle are resolved as erase first, then normal program, then additional program.
- R12: `prog_en` and `erase_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| start_prog | input | 1 | Start a normal program sequence |
| start_addprog | input | 1 | Start an additional-program sequence |
| start_erase | input | 1 | Start an erase sequence |
| erase_ms | input | MS_W | Erase pulse width in milliseconds, captured at erase start |
| erase_max | input | CNT_W | Maximum erase attempts, captured at erase start |
| verify_done | input | 1 | Verify stage has a verdict this cycle |
| verify_pass | input | 1 | Verdict, valid with `verify_done` (1 = pass) |
| prog_en | output | 1 | Program pulse enable to the array |
| erase_en | output | 1 | Erase pulse enable to the array |
| verify_req | output | 1 | Requests a verify; held until `verify_done` |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | With `done`: the sequence ran out of attempts |

## Verification
The bench builds the block with SHORT_US=4, LONG_US=9, ADD_US=2, SWITCH_N=3, PROG_MAX=5, ADD_MAX=3, US_PER_MS=3, MS_W=4 and CNT_W=4. With these values every pulse lasts only a few ticks. The switch from short to long program pulses happens by the fourth attempt, so a normal program sequence can be run to its full attempt ceiling, as can the additional-program and erase ceilings. The 1 µs strobe is fed either every cycle or every third cycle, which shows that the pulse width follows ticks and not clocks.

// File: rtl/fpe_pkg.sv
// Shared types for the flash pulse sequencer.
// Assumes: no more than three operations and three control states.
package fpe_pkg;
    typedef enum logic [1:0] {OP_PROG, OP_ADD, OP_ERASE} fpe_op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_VERIFY} fpe_st_e;
endpackage

// File: rtl/fpe_tick_timer.sv
// Dwell timer: counts us ticks while run is high and flags the tick that
// completes target ticks. A target of 0 behaves as 1.
// Assumes: target is held stable while run is high.
module fpe_tick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] target,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    // Completion: this tick brings the count to the target.
    assign expire = run && tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, target});

    // Tick counter, cleared outside a pulse and on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run || expire)    cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && target != '0) |-> (cnt_q < target)); // R10
endmodule

// File: rtl/fpe_attempt_ctr.sv
// Attempt counter: loads 1 at sequence start and steps once per failed
// verify. Reports when the count has reached the allowed limit.
// Assumes: step is only raised while below the limit.
module fpe_attempt_ctr #(
    parameter int NW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [NW-1:0] limit,
    output logic [NW-1:0] n,
    output logic          at_limit
);
    logic [NW-1:0] n_q;

    assign n        = n_q;
    assign at_limit = (n_q >= limit);

    // Attempt number register.
    always_ff @(posedge clk) begin
        if (!rst_n)     n_q <= '0;
        else if (load)  n_q <= {{(NW-1){1'b0}}, 1'b1};
        else if (step)  n_q <= n_q + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !at_limit); // R8
endmodule

// File: rtl/fpe_dwell_sel.sv
// Dwell and limit selection: picks the pulse width in ticks and the attempt
// ceiling from the operation, the attempt number and the captured erase
// settings. Purely combinational.
// Assumes: TW and NW are wide enough for every value produced.
module fpe_dwell_sel
    import fpe_pkg::*;
#(
    parameter int SHORT_US  = 30,
    parameter int LONG_US   = 200,
    parameter int ADD_US    = 10,
    parameter int SWITCH_N  = 6,
    parameter int PROG_MAX  = 1000,
    parameter int ADD_MAX   = 6,
    parameter int US_PER_MS = 1000,
    parameter int MS_W      = 8,
    parameter int CNT_W     = 8,
    parameter int TW        = 18,
    parameter int NW        = 10
) (
    input  fpe_op_e          op,
    input  logic [NW-1:0]    n,
    input  logic [MS_W-1:0]  ms,
    input  logic [CNT_W-1:0] emax,
    output logic [TW-1:0]    target,
    output logic [NW-1:0]    limit
);
    // Width and ceiling for the active operation.
    always_comb begin
        unique case (op)
            OP_ADD: begin
                target = TW'(ADD_US);
                limit  = NW'(ADD_MAX);
            end
            OP_ERASE: begin
                target = TW'(ms) * TW'(US_PER_MS);
                limit  = NW'(emax);
            end
            default: begin
                target = (n <= NW'(SWITCH_N)) ? TW'(SHORT_US) : TW'(LONG_US);
                limit  = NW'(PROG_MAX);
            end
        endcase
    end
endmodule

// File: rtl/fpe_pulse_seq.sv
// Flash program/erase pulse sequencer (top). Runs pulse -> verify -> retry
// until pass or the attempt ceiling, then signals done (and fail).
// Assumes: us_tick is a one-cycle strobe; the verify stage answers each
// verify_req with exactly one verify_done.
module fpe_pulse_seq
    import fpe_pkg::*;
#(
    parameter int SHORT_US  = 30,
    parameter int LONG_US   = 200,
    parameter int ADD_US    = 10,
    parameter int SWITCH_N  = 6,
    parameter int PROG_MAX  = 1000,
    parameter int ADD_MAX   = 6,
    parameter int US_PER_MS = 1000,
    parameter int MS_W      = 8,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             start_prog,
    input  logic             start_addprog,
    input  logic             start_erase,
    input  logic [MS_W-1:0]  erase_ms,
    input  logic [CNT_W-1:0] erase_max,
    input  logic             verify_done,
    input  logic             verify_pass,
    output logic             prog_en,
    output logic             erase_en,
    output logic             verify_req,
    output logic             done,
    output logic             fail
);
    localparam int ERASE_TOP = ((1 << MS_W) - 1) * US_PER_MS;
    localparam int PROG_TOP  = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
    localparam int PA_TOP    = (PROG_TOP > ADD_US) ? PROG_TOP : ADD_US;
    localparam int T_MAX     = (ERASE_TOP > PA_TOP) ? ERASE_TOP : PA_TOP;
    localparam int TW        = $clog2(T_MAX + 1);
    localparam int EC_TOP    = (1 << CNT_W) - 1;
    localparam int PC_TOP    = (PROG_MAX > ADD_MAX) ? PROG_MAX : ADD_MAX;
    localparam int N_MAX     = (PC_TOP > EC_TOP) ? PC_TOP : EC_TOP;
    localparam int NW        = $clog2(N_MAX + 1);

    fpe_st_e          state_q;
    fpe_op_e          op_q;
    logic [MS_W-1:0]  ms_q;
    logic [CNT_W-1:0] emax_q;
    logic             done_q, fail_q;
    logic             start_any, ctr_load, ctr_step, expire, at_limit;
    logic [NW-1:0]    n;
    logic [NW-1:0]    limit;
    logic [TW-1:0]    target;

    assign start_any = start_prog | start_addprog | start_erase;
    assign ctr_load  = (state_q == ST_IDLE) && start_any;
    assign ctr_step  = (state_q == ST_VERIFY) && verify_done && !verify_pass && !at_limit;

    fpe_dwell_sel #(
        .SHORT_US(SHORT_US), .LONG_US(LONG_US), .ADD_US(ADD_US),
        .SWITCH_N(SWITCH_N), .PROG_MAX(PROG_MAX), .ADD_MAX(ADD_MAX),
        .US_PER_MS(US_PER_MS), .MS_W(MS_W), .CNT_W(CNT_W), .TW(TW), .NW(NW)
    ) u_sel (
        .op(op_q), .n(n), .ms(ms_q), .emax(emax_q),
        .target(target), .limit(limit)
    );

    fpe_attempt_ctr #(.NW(NW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .step(ctr_step),
        .limit(limit), .n(n), .at_limit(at_limit)
    );

    fpe_tick_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_PULSE), .tick(us_tick),
        .target(target), .expire(expire)
    );

    // Sequence control: start arbitration, pulse/verify loop, end status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROG;
            ms_q    <= '0;
            emax_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_any) begin
                    state_q <= ST_PULSE;
                    if (start_erase) begin
                        op_q   <= OP_ERASE;
                        ms_q   <= erase_ms;
                        emax_q <= erase_max;
                    end else if (start_prog) begin
                        op_q <= OP_PROG;
                    end else begin
                        op_q <= OP_ADD;
                    end
                end
                ST_PULSE: if (expire) state_q <= ST_VERIFY;
                ST_VERIFY: if (verify_done) begin
                    if (verify_pass) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (at_limit) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_PULSE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and captured operation.
    assign prog_en    = (state_q == ST_PULSE) && (op_q != OP_ERASE);
    assign erase_en   = (state_q == ST_PULSE) && (op_q == OP_ERASE);
    assign verify_req = (state_q == ST_VERIFY);
    assign done       = done_q;
    assign fail       = fail_q;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en)); // R12
    AST_EN_DROP_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_en) || $fell(erase_en)) |-> verify_req); // R6
    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req |-> (!prog_en && !erase_en)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R8
    AST_ERASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(ms_q) && $stable(emax_q))); // R5
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && op_q != OP_ERASE) |=> !erase_en); // R9
endmodule

// File: tb/fpe_pulse_seq_tb.sv
module fpe_pulse_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_US = 4, LONG_US = 9, ADD_US = 2, SWITCH_N = 3;
    localparam int PROG_MAX = 5, ADD_MAX = 3, US_PER_MS = 3;
    localparam int MS_W = 4, CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0;
    logic start_prog = 1'b0, start_addprog = 1'b0, start_erase = 1'b0;
    logic [MS_W-1:0]  erase_ms = '0;
    logic [CNT_W-1:0] erase_max = '0;
    logic verify_done = 1'b0, verify_pass = 1'b0;
    logic prog_en, erase_en, verify_req, done, fail;

    int total = 0;
    int bad = 0;
    int tick_div = 1;
    int er_ms_exp = 0;
    bit finished = 1'b0;

    fpe_pulse_seq #(
        .SHORT_US(SHORT_US), .LONG_US(LONG_US), .ADD_US(ADD_US),
        .SWITCH_N(SWITCH_N), .PROG_MAX(PROG_MAX), .ADD_MAX(ADD_MAX),
        .US_PER_MS(US_PER_MS), .MS_W(MS_W), .CNT_W(CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .start_prog(start_prog), .start_addprog(start_addprog),
        .start_erase(start_erase), .erase_ms(erase_ms), .erase_max(erase_max),
        .verify_done(verify_done), .verify_pass(verify_pass),
        .prog_en(prog_en), .erase_en(erase_en), .verify_req(verify_req),
        .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick source, driven on the falling edge.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            us_tick = (k % tick_div) == 0;
            k++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ticks(input int op, input int a);
        if (op == 2) return er_ms_exp * US_PER_MS;
        if (op == 1) return ADD_US;
        return (a <= SWITCH_N) ? SHORT_US : LONG_US;
    endfunction

    function automatic logic cur_en(input int op);
        return (op == 2) ? erase_en : prog_en;
    endfunction

    function automatic logic oth_en(input int op);
        return (op == 2) ? prog_en : erase_en;
    endfunction

    task automatic clear_starts();
        start_prog = 1'b0; start_addprog = 1'b0; start_erase = 1'b0;
    endtask

    // Generic sequence: mask bit0 prog, bit1 addprog, bit2 erase; op is the
    // expected winner (0 prog, 1 addprog, 2 erase); pass_at 0 = never.
    task automatic run_seq(input int mask, input int op, input int pass_at,
                           input int exp_n, input bit exp_fail, input bit noise,
                           input string req);
        int a = 0;
        bit fin = 1'b0;
        @(negedge clk);
        start_prog = mask[0]; start_addprog = mask[1]; start_erase = mask[2];
        @(negedge clk);
        clear_starts();
        if (op == 2) begin
            erase_ms = 4'd9; erase_max = 4'd9;  // R5: must be ignored
        end
        while (!fin && a < exp_n + 2) begin
            int w = 0, ticks = 0, cyc = 0, clash = 0;
            a++;
            while (cur_en(op) == 1'b0 && w < 2000) begin
                @(negedge clk); w++;
            end
            if (w >= 2000) begin
                check(1'b0, req, "pulse never started", 0, 1);
                fin = 1'b1;
            end else begin
                while (cur_en(op) == 1'b1 && cyc < 5000) begin
                    if (oth_en(op)) clash++;
                    if (us_tick) ticks++;
                    cyc++;
                    if (noise && cyc == 2) begin
                        start_prog = 1'b1; start_addprog = 1'b1; start_erase = 1'b1;
                    end else clear_starts();
                    @(negedge clk);
                end
                clear_starts();
                check(clash == 0, "R12", "both enables high", clash, 0);
                check(ticks == exp_ticks(op, a), req, $sformatf("pulse ticks attempt %0d", a),
                      ticks, exp_ticks(op, a));
                if (tick_div > 1)
                    check(cyc > ticks, "R10", "clock cycles exceed ticks", cyc, ticks + 1);
                check(verify_req == 1'b1, "R6", "verify_req after pulse", verify_req, 1);
                repeat (3) @(negedge clk);
                check(verify_req && !prog_en && !erase_en, "R6", "verify held, enables low",
                      {verify_req, prog_en, erase_en}, 3'b100);
                verify_done = 1'b1;
                verify_pass = (a == pass_at);
                if (noise) start_erase = 1'b1;
                @(negedge clk);
                verify_done = 1'b0; verify_pass = 1'b0; clear_starts();
                if (a == pass_at || a == exp_n) begin
                    check(done == 1'b1, (a == pass_at) ? "R7" : "R8", "done at end", done, 1);
                    check(fail == exp_fail, (a == pass_at) ? "R7" : "R8", "fail at end", fail, exp_fail);
                    fin = 1'b1;
                    @(negedge clk);
                    check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
                end else begin
                    check(done == 1'b0, "R8", "no done mid-sequence", done, 0);
                end
            end
        end
        check(a == exp_n, req, "attempt count", a, exp_n);
        begin
            int act = 0;
            repeat (6) begin
                @(negedge clk);
                if (prog_en || erase_en || verify_req) act++;
            end
            check(act == 0, noise ? "R9" : req, "idle after end", act, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({prog_en, erase_en, verify_req, done, fail} == 5'b0, "R1", "outputs in reset",
              {prog_en, erase_en, verify_req, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({prog_en, erase_en, verify_req, done, fail} == 5'b0, "R1", "outputs after reset",
              {prog_en, erase_en, verify_req, done, fail}, 0);
    endtask

    task automatic t_prog_first_pass();   run_seq(1, 0, 1, 1, 1'b0, 1'b0, "R2"); endtask
    task automatic t_prog_late_pass();    run_seq(1, 0, 5, 5, 1'b0, 1'b0, "R3"); endtask
    task automatic t_prog_exhaust();      run_seq(1, 0, 0, PROG_MAX, 1'b1, 1'b0, "R3"); endtask
    task automatic t_addprog_exhaust();   run_seq(2, 1, 0, ADD_MAX, 1'b1, 1'b0, "R4"); endtask

    task automatic t_erase_exhaust();
        erase_ms = 4'd2; erase_max = 4'd3; er_ms_exp = 2;
        run_seq(4, 2, 0, 3, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_erase_zero_max();
        erase_ms = 4'd1; erase_max = 4'd0; er_ms_exp = 1;
        run_seq(4, 2, 0, 1, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_busy_starts();       run_seq(1, 0, 2, 2, 1'b0, 1'b1, "R9"); endtask

    task automatic t_priority();
        erase_ms = 4'd1; erase_max = 4'd2; er_ms_exp = 1;
        run_seq(7, 2, 1, 1, 1'b0, 1'b0, "R11");
        run_seq(3, 0, 1, 1, 1'b0, 1'b0, "R11");
    endtask

    task automatic t_slow_tick();
        tick_div = 3;
        run_seq(1, 0, 1, 1, 1'b0, 1'b0, "R10");
        tick_div = 1;
    endtask

    initial begin
        t_reset();
        t_prog_first_pass();
        t_prog_late_pass();
        t_prog_exhaust();
        t_addprog_exhaust();
        t_erase_exhaust();
        t_erase_zero_max();
        t_busy_starts();
        t_priority();
        t_slow_tick();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule